// File: doc/BRIEF.md
# Modulo-Interleaved Bank Address Mapper

This unit turns a linear word address into a bank index and an in-bank word index for a memory built from a prime number of banks. The bank count is 2^BANK_K − 1. The bank index is the address modulo that count. The in-bank index is the address modulo the words per bank, which is 2^OFS_BITS. The two moduli share no factor, so every address below the capacity (bank count × words per bank) lands on its own (bank, word) pair. Power-of-two strides, which would keep hitting a single bank in a power-of-two banked memory, rotate through all banks here.

The remainder modulo 2^BANK_K − 1 is built from additions only. The address is cut into BANK_K-bit chunks and the chunks are summed. The sum is then folded repeatedly: the low BANK_K bits are added to the bits above them, which acts as an end-around carry. Each fold sits in its own register stage, so no wide carry chain spans a whole cycle. An address at or above the capacity is flagged.

Both data sides use valid/ready handshakes. An item moves when valid and ready are both high at a rising clock edge. Back-pressure stalls the whole pipeline as a unit: while `out_valid` is high and `out_ready` is low, every stage holds and `in_ready` is low. In every other cycle `in_ready` is high and the pipeline advances. Bubbles that are already in the pipeline are not squeezed out during a stall.

Top module: `modbank_mapper`

## Requirements
- R1: For an accepted address a below the capacity, `out_bank` equals a mod (2^BANK_K − 1). With the defaults this is a mod 3.
- R2: For an accepted address a below the capacity, `out_offset` equals a mod 2^OFS_BITS. With the defaults this is a mod 8.
- R3: Over all addresses from 0 to capacity − 1, no (out_bank, out_offset) pair occurs twice, and every pair occurs exactly once. With the defaults the capacity is 24.
- R4: With the defaults, address 8 yields bank 2, word 0, and address 16 yields bank 1, word 0.
- R5: `out_oor` is 1 exactly when the accepted address is at or above the capacity (24 by default). When `out_oor` is 1, `out_bank` and `out_offset` carry no meaning.
- R6: With `out_ready` held high, results leave in acceptance order. A result appears on `out_valid` 5 rising edges after its acceptance edge with the defaults. One item can be accepted per cycle.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_bank`, `out_offset`, `out_oor` and `out_valid` keep their values on the next cycle.
- R8: During and right after an active-low reset, `out_valid` is 0 and `in_ready` is 1.
- R9: Power-of-two strides of 4, 8 and 16 (addresses taken modulo the capacity) reach every bank within six consecutive accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Mapper can take an address this cycle |
| in_addr | input | ADDR_W | Linear word address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_bank | output | BANK_K | Bank index |
| out_offset | output | OFS_BITS | Word index inside the bank |
| out_oor | output | 1 | Address at or beyond capacity |

## Verification
Embedded properties check several things on every cycle. The chunk-sum stage and every fold stage must keep the value's remainder modulo the bank count. A presented bank index is never the reserved value 2^BANK_K − 1. A stalled output must hold its value.

Some behaviours can only be shown by the bench's scenarios:
- the exact bank and word values for every address;
- the one-to-one coverage of all 24 pairs;
- the out-of-range flag at the capacity boundary;
- the five-cycle latency;
- the rotation of power-of-two strides across banks;
- order preservation under random back-pressure.

// File: rtl/mm_pkg.sv
package mm_pkg;

  function automatic int mm_chunks(input int aw, input int k);
    return (aw + k - 1) / k;
  endfunction

  // Width holding the sum of all k-bit chunks of an aw-bit address
  function automatic int mm_sum_w(input int aw, input int k);
    int n;
    n = mm_chunks(aw, k);
    if (n > 1) return k + $clog2(n);
    return k;
  endfunction

  // Width after one end-around fold of a w-bit value
  function automatic int mm_fold_w(input int w, input int k);
    int hi;
    hi = w - k;
    return ((hi > k) ? hi : k) + 1;
  endfunction

  // Width entering fold stage i (i = 0 is the chunk sum)
  function automatic int mm_stage_w(input int aw, input int k, input int i);
    int w;
    w = mm_sum_w(aw, k);
    for (int j = 0; j < i; j++) w = mm_fold_w(w, k);
    return w;
  endfunction

  // Folds until k+1 bits, then two more reach a value <= 2^k-1
  function automatic int mm_fold_n(input int aw, input int k);
    int w;
    int n;
    w = mm_sum_w(aw, k);
    n = 0;
    while (w > k + 1) begin
      w = mm_fold_w(w, k);
      n++;
    end
    return n + 2;
  endfunction

endpackage

// File: rtl/mm_chunk_sum.sv
module mm_chunk_sum #(
  parameter int ADDR_W = 5,
  parameter int K      = 2,
  parameter int OFS_W  = 3,
  parameter int CAP    = 24,
  parameter int SUM_W  = 4,
  parameter int SIDE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              v_q,
  output logic [SUM_W-1:0]  sum_q,
  output logic [SIDE_W-1:0] side_q
);
  localparam int N     = mm_pkg::mm_chunks(ADDR_W, K);
  localparam int PAD_W = N * K;
  localparam int MOD   = (1 << K) - 1;

  logic [PAD_W-1:0]  padded;
  logic [SUM_W-1:0]  sum_c;
  logic              oor_c;

  assign padded = PAD_W'(addr_i);
  assign oor_c  = ({1'b0, addr_i} >= (ADDR_W + 1)'(CAP));

  always_comb begin
    sum_c = '0;
    for (int c = 0; c < N; c++) sum_c = sum_c + SUM_W'(padded[c*K +: K]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      sum_q  <= '0;
      side_q <= '0;
    end else if (en) begin
      v_q    <= in_valid;
      sum_q  <= sum_c;
      side_q <= {oor_c, addr_i[OFS_W-1:0]};
    end
  end

  AST_SUM_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_valid) |=> ((32'(sum_q) % MOD) == (32'($past(addr_i)) % MOD))); // R1

endmodule

// File: rtl/mm_fold_stage.sv
module mm_fold_stage #(
  parameter int K      = 2,
  parameter int IW     = 4,
  parameter int OW     = 3,
  parameter int SIDE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic [IW-1:0]     in_res,
  input  logic [SIDE_W-1:0] in_side,
  output logic              out_valid,
  output logic [OW-1:0]     out_res,
  output logic [SIDE_W-1:0] out_side
);
  localparam int MOD  = (1 << K) - 1;
  localparam int HI_W = IW - K;

  logic [OW-1:0] lo_x;
  logic [OW-1:0] hi_x;
  logic [OW-1:0] fold_c;

  assign lo_x   = {{(OW - K){1'b0}}, in_res[K-1:0]};
  assign hi_x   = {{(OW - HI_W){1'b0}}, in_res[IW-1:K]};
  assign fold_c = lo_x + hi_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_side  <= '0;
    end else if (en) begin
      out_valid <= in_valid;
      out_res   <= fold_c;
      out_side  <= in_side;
    end
  end

  AST_FOLD_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_valid) |=> ((32'(out_res) % MOD) == (32'($past(in_res)) % MOD))); // R1

endmodule

// File: rtl/modbank_mapper.sv
module modbank_mapper #(
  parameter int BANK_K   = 2,
  parameter int OFS_BITS = 3,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [ADDR_W-1:0]   in_addr,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [BANK_K-1:0]   out_bank,
  output logic [OFS_BITS-1:0] out_offset,
  output logic                out_oor
);
  localparam int NB     = (1 << BANK_K) - 1;
  localparam int WPB    = 1 << OFS_BITS;
  localparam int CAP    = NB * WPB;
  localparam int SIDE_W = OFS_BITS + 1;
  localparam int SUM_W  = mm_pkg::mm_sum_w(ADDR_W, BANK_K);
  localparam int NFOLD  = mm_pkg::mm_fold_n(ADDR_W, BANK_K);

  logic              adv;
  logic              s0_v;
  logic [SUM_W-1:0]  s0_r;
  logic [SIDE_W-1:0] s0_s;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  mm_chunk_sum #(
    .ADDR_W(ADDR_W), .K(BANK_K), .OFS_W(OFS_BITS), .CAP(CAP),
    .SUM_W(SUM_W), .SIDE_W(SIDE_W)
  ) u_sum (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_valid(in_valid),
    .addr_i(in_addr), .v_q(s0_v), .sum_q(s0_r), .side_q(s0_s)
  );

  for (genvar i = 0; i < NFOLD; i++) begin : g_fold
    localparam int IW = mm_pkg::mm_stage_w(ADDR_W, BANK_K, i);
    localparam int OW = mm_pkg::mm_stage_w(ADDR_W, BANK_K, i + 1);
    logic              src_v;
    logic [IW-1:0]     src_r;
    logic [SIDE_W-1:0] src_s;
    logic              v;
    logic [OW-1:0]     r;
    logic [SIDE_W-1:0] s;
    if (i == 0) begin : g_first
      assign src_v = s0_v;
      assign src_r = s0_r;
      assign src_s = s0_s;
    end else begin : g_next
      assign src_v = g_fold[i-1].v;
      assign src_r = g_fold[i-1].r;
      assign src_s = g_fold[i-1].s;
    end
    mm_fold_stage #(.K(BANK_K), .IW(IW), .OW(OW), .SIDE_W(SIDE_W)) u_fold (
      .clk(clk), .rst_n(rst_n), .en(adv), .in_valid(src_v), .in_res(src_r),
      .in_side(src_s), .out_valid(v), .out_res(r), .out_side(s)
    );
  end

  logic [BANK_K:0]   fin_r;
  logic [SIDE_W-1:0] fin_s;
  logic              fin_v;
  logic [BANK_K-1:0] bank_c;

  assign fin_r  = g_fold[NFOLD-1].r;
  assign fin_s  = g_fold[NFOLD-1].s;
  assign fin_v  = g_fold[NFOLD-1].v;
  // after the folds the value is at most NB; NB itself is residue zero
  assign bank_c = (fin_r == (BANK_K + 1)'(NB)) ? '0 : fin_r[BANK_K-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_bank   <= '0;
      out_offset <= '0;
      out_oor    <= 1'b0;
    end else if (adv) begin
      out_valid  <= fin_v;
      out_bank   <= bank_c;
      out_offset <= fin_s[OFS_BITS-1:0];
      out_oor    <= fin_s[OFS_BITS];
    end
  end

  AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bank != BANK_K'(NB))); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bank) &&
                                   $stable(out_offset) && $stable(out_oor))); // R7

endmodule

// File: tb/modbank_mapper_tb.sv
`timescale 1ns/1ps
module modbank_mapper_tb;
  localparam int K   = 2;
  localparam int OB  = 3;
  localparam int AW  = 5;
  localparam int NB  = 3;
  localparam int WPB = 8;
  localparam int CAP = 24;
  localparam int LAT = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_addr = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [K-1:0]  out_bank;
  logic [OB-1:0] out_offset;
  logic          out_oor;

  always #10 clk = ~clk;

  modbank_mapper #(.BANK_K(K), .OFS_BITS(OB), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_bank(out_bank), .out_offset(out_offset), .out_oor(out_oor)
  );

  int nvec = 0;
  int nbad = 0;
  int q_exp[$];
  bit rand_ready = 1'b0;
  bit track_unique = 1'b0;
  bit track_stride = 1'b0;
  bit seen [CAP];
  int bank_mask = 0;
  bit prev_stall = 1'b0;
  logic [K-1:0]  pb;
  logic [OB-1:0] po;
  logic          pr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rand_ready) out_ready = ($urandom_range(0, 1) == 1);
    else out_ready = 1'b1;
  end

  // Monitor: pops the scoreboard on each output transfer
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_stall) begin
        chk(out_valid && out_bank == pb && out_offset == po && out_oor == pr,
            "R7", "held output after stall", int'(out_bank), int'(pb));
      end
      if (out_valid && !out_ready)
        chk(!in_ready, "R7", "in_ready during stall", int'(in_ready), 0);
      prev_stall = out_valid && !out_ready;
      pb = out_bank; po = out_offset; pr = out_oor;
      if (out_valid && out_ready) begin
        if (q_exp.size() == 0) begin
          chk(1'b0, "R6", "output with empty scoreboard", 1, 0);
        end else begin
          int a;
          bit eoor;
          a = q_exp.pop_front();
          eoor = (a >= CAP);
          chk(out_oor == eoor, "R5", $sformatf("oor flag addr %0d", a),
              int'(out_oor), int'(eoor));
          if (!eoor) begin
            chk(int'(out_bank) == a % NB, "R1", $sformatf("bank addr %0d", a),
                int'(out_bank), a % NB);
            chk(int'(out_offset) == a % WPB, "R2", $sformatf("offset addr %0d", a),
                int'(out_offset), a % WPB);
            if (track_unique && int'(out_bank) < NB) begin
              int idx;
              idx = int'(out_bank) * WPB + int'(out_offset);
              chk(!seen[idx], "R3", $sformatf("pair reused addr %0d", a), 1, 0);
              seen[idx] = 1'b1;
            end
            if (track_stride) bank_mask = bank_mask | (1 << int'(out_bank));
          end
        end
      end
    end
  end

  // Driver: offers one address, records it once the handshake is certain
  task automatic send(input int a);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = AW'(a);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    q_exp.push_back(a);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (q_exp.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(q_exp.size() == 0, "R6", "scoreboard drained", q_exp.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic latency_probe(input int a, input int eb);
    int cnt;
    send(a);
    cnt = 0;
    while (!out_valid && cnt < 20) begin
      @(negedge clk);
      in_valid = 1'b0;
      #3;
      cnt++;
    end
    chk(cnt == LAT, "R6", $sformatf("latency addr %0d", a), cnt, LAT);
    chk(int'(out_bank) == eb && out_offset == '0, "R4",
        $sformatf("bank for addr %0d", a), int'(out_bank), eb);
    drain();
  endtask

  initial begin
    #(20 * 150000);
    nbad++;
    $display("FAIL R6 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    chk(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R8", "in_ready after reset", int'(in_ready), 1);

    // R4 / R6: reference addresses and pipeline latency
    latency_probe(8, 2);
    latency_probe(16, 1);

    // R1 R2 R3 R5: full sweep, back to back, including out-of-range tail
    for (int i = 0; i < CAP; i++) seen[i] = 1'b0;
    track_unique = 1'b1;
    for (int a = 0; a < 32; a++) send(a);
    idle();
    drain();
    track_unique = 1'b0;
    begin
      int hits;
      hits = 0;
      for (int i = 0; i < CAP; i++) hits += int'(seen[i]);
      chk(hits == CAP, "R3", "distinct pairs covered", hits, CAP);
    end

    // R9: power-of-two strides rotate over all banks
    for (int si = 0; si < 3; si++) begin
      int s;
      s = 4 << si;
      bank_mask = 0;
      track_stride = 1'b1;
      for (int k = 0; k < 6; k++) send((k * s) % CAP);
      idle();
      drain();
      track_stride = 1'b0;
      chk(bank_mask == 7, "R9", $sformatf("banks reached stride %0d", s), bank_mask, 7);
    end

    // R7: random addresses under random back-pressure
    rand_ready = 1'b1;
    for (int n = 0; n < 300; n++) send($urandom_range(0, 31));
    idle();
    drain();
    rand_ready = 1'b0;
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule